// File: doc/BRIEF.md
# Character LCD Text Sequencer

This block drives a two-row, sixteen-column character LCD through a plain byte write port: a one-cycle write strobe, a select line that marks the byte as display data or as a controller command, and the byte itself. Once reset is released it sends the power-up command list without outside help. It then waits at an idle point where it takes one request at a time from a valid/ready stream. A request clears the screen, moves the cursor to a row and column, moves it to the start of a numbered line, or writes one character.

Each request that is accepted becomes exactly one byte on the port. A settling interval follows every byte, and the interval is counted in clock cycles from the clock rate parameter. The slow clear command gets a longer interval. A request that names a position outside the screen is refused with a one-cycle error pulse, and no byte is sent for it.

Top module: `lcd_text_seq`

## Requirements
- R1: While reset is held, `lcd_we`, `req_ready` and `req_err` are all low.
- R2: After reset the block sends five command bytes (`lcd_rs`=0), in this order: 0x38, 0x0C, 0x01, 0x06, 0x80.
- R3: Every byte is followed by a settle of S = CLK_MHZ*100 cycles. During power-up the next strobe comes exactly S+2 cycles after the previous one. After a request's strobe, `req_ready` rises again exactly S+1 cycles later.
- R4: A clear command byte (0x01 with `lcd_rs`=0) uses a settle of C = CLK_MHZ*CLEAR_US cycles instead of S, both during power-up and on request.
- R5: `req_ready` is high only in the idle state after power-up. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. Its strobe is high for exactly one cycle, in the cycle after acceptance. `req_kind` encodes 0 = character, 1 = clear, 2 = row/column, 3 = line.
- R6: A character request sends `req_char` with `lcd_rs`=1.
- R7: A clear request sends 0x01 with `lcd_rs`=0.
- R8: A row/column request with `req_row` < ROWS and `req_col` < COLS sends a command byte equal to 0x80 + 0x40*row[0] + COLS*row[1] + col. This gives 0x80 for row 0 and 0xC0 for row 1.
- R9: A line request reads `req_row` as a line number from 1 to ROWS and sends the base code of row line-1 (line 1 gives 0x80, line 2 gives 0xC0).
- R10: A row/column or line request that is out of range gives `req_err` high for exactly the one cycle after acceptance. No strobe follows, and `req_ready` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Idle and able to take a request |
| req_kind | input | 2 | Request kind: 0 character, 1 clear, 2 row/column, 3 line |
| req_char | input | 8 | Character code for a character request |
| req_row | input | ROW_W | Row (0-based) or line number (1-based) |
| req_col | input | COL_W | Column for a row/column request |
| req_err | output | 1 | One-cycle pulse for a refused request |
| lcd_we | output | 1 | One-cycle byte write strobe |
| lcd_rs | output | 1 | 1 = display data, 0 = command |
| lcd_byte | output | 8 | Byte being written |

## Verification
The checker assumes the request fields are stable in the cycle where `req_valid` and `req_ready` are both high. It also assumes the source only offers requests through that handshake. The stimulus raises `req_valid` on a falling edge while `req_ready` is high and drops it on the next falling edge, so each handshake takes exactly one request. Because of this, the spacing check between strobes never sees two requests stacked inside one settle window.

// File: rtl/lcd_seq_pkg.sv
package lcd_seq_pkg;

  typedef enum logic [1:0] {
    K_CHAR  = 2'd0,
    K_CLEAR = 2'd1,
    K_XY    = 2'd2,
    K_LINE  = 2'd3
  } req_kind_e;

  typedef enum logic [2:0] {
    S_RST   = 3'd0,
    S_INIT  = 3'd1,
    S_ISSUE = 3'd2,
    S_WAIT  = 3'd3,
    S_IDLE  = 3'd4
  } seq_state_e;

  localparam logic [7:0] CMD_CLEAR = 8'h01;
  localparam int INIT_LEN = 5;

  // set-address code for the first cell of a row: odd rows sit 0x40 up,
  // rows 2 and 3 continue one row width past rows 0 and 1
  function automatic int unsigned row_base(int unsigned row, int unsigned cols);
    return 32'd128 + ((row & 32'd1) * 32'd64) + ((row >> 1) * cols);
  endfunction

endpackage

// File: rtl/lcd_seq_init_rom.sv
module lcd_seq_init_rom
  import lcd_seq_pkg::*;
#(
  parameter int COLS   = 16,
  parameter int STEP_W = 3
) (
  input  logic [STEP_W-1:0] step,
  output logic [7:0]        code
);

  logic [31:0] home;

  always_comb begin
    home = 32'(row_base(32'd0, 32'(COLS)));
    case (step)
      STEP_W'(0): code = 8'h38;   // 8-bit bus, two lines
      STEP_W'(1): code = 8'h0C;   // display on, cursor hidden
      STEP_W'(2): code = CMD_CLEAR;
      STEP_W'(3): code = 8'h06;   // increment after each write
      default:    code = home[7:0];
    endcase
  end

endmodule

// File: rtl/lcd_seq_decode.sv
module lcd_seq_decode
  import lcd_seq_pkg::*;
#(
  parameter int ROWS  = 2,
  parameter int COLS  = 16,
  parameter int ROW_W = 2,
  parameter int COL_W = 5
) (
  input  logic [1:0]       kind,
  input  logic [7:0]       chr,
  input  logic [ROW_W-1:0] row,
  input  logic [COL_W-1:0] col,
  output logic             ok,
  output logic             rs,
  output logic [7:0]       code
);

  req_kind_e   k;
  int unsigned r;
  int unsigned c;
  logic [31:0] sum;

  assign k = req_kind_e'(kind);

  always_comb begin
    r    = 32'(row);
    c    = 32'(col);
    sum  = 32'd0;
    ok   = 1'b1;
    rs   = 1'b0;
    code = 8'h00;
    case (k)
      K_CHAR: begin
        rs   = 1'b1;
        code = chr;
      end
      K_CLEAR: code = CMD_CLEAR;
      K_XY: begin
        ok   = (r < 32'(ROWS)) && (c < 32'(COLS));
        sum  = row_base(r, 32'(COLS)) + c;
        code = sum[7:0];
      end
      default: begin
        ok   = (r >= 32'd1) && (r <= 32'(ROWS));
        sum  = row_base((r == 32'd0) ? 32'd0 : r - 32'd1, 32'(COLS));
        code = sum[7:0];
      end
    endcase
  end

endmodule

// File: rtl/lcd_seq_timer.sv
module lcd_seq_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             en,
  output logic             done
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  assign cnt_en = load || (en && (cnt_q != '0));
  assign cnt_d  = load ? load_val : cnt_q - CNT_W'(1);
  assign done   = (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

endmodule

// File: rtl/lcd_text_seq.sv
module lcd_text_seq
  import lcd_seq_pkg::*;
#(
  parameter int CLK_MHZ  = 100,
  parameter int CLEAR_US = 2000,
  parameter int ROWS     = 2,
  parameter int COLS     = 16,
  parameter int ROW_W    = 2,
  parameter int COL_W    = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [1:0]       req_kind,
  input  logic [7:0]       req_char,
  input  logic [ROW_W-1:0] req_row,
  input  logic [COL_W-1:0] req_col,
  output logic             req_err,
  output logic             lcd_we,
  output logic             lcd_rs,
  output logic [7:0]       lcd_byte
);

  localparam int SETTLE     = CLK_MHZ * 100;
  localparam int CLR_SETTLE = CLK_MHZ * CLEAR_US;
  localparam int LONGEST    = (CLR_SETTLE > SETTLE) ? CLR_SETTLE : SETTLE;
  localparam int CNT_W      = $clog2(LONGEST + 1);
  localparam int STEP_W     = $clog2(INIT_LEN + 1);
  localparam logic [CNT_W-1:0]  SET_M1  = CNT_W'(SETTLE - 1);
  localparam logic [CNT_W-1:0]  CLR_M1  = CNT_W'(CLR_SETTLE - 1);
  localparam logic [STEP_W-1:0] LAST    = STEP_W'(INIT_LEN - 1);
  localparam logic [STEP_W-1:0] FINISH  = STEP_W'(INIT_LEN);

  // reset: asserts at once, leaves two edges later
  logic [1:0] rsync_q;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_i_n = rsync_q[1];

  seq_state_e        st_q, st_d;
  logic [STEP_W-1:0] step_q, step_d;
  logic [7:0]        byte_q, byte_d;
  logic              rs_q, rs_d;
  logic              err_q, err_d;

  logic [7:0]        rom_code;
  logic              dec_ok, dec_rs;
  logic [7:0]        dec_code;
  logic              tmr_load, tmr_done;
  logic [CNT_W-1:0]  tmr_val;

  lcd_seq_init_rom #(.COLS(COLS), .STEP_W(STEP_W)) u_rom (
    .step (step_q),
    .code (rom_code)
  );

  lcd_seq_decode #(.ROWS(ROWS), .COLS(COLS), .ROW_W(ROW_W), .COL_W(COL_W)) u_dec (
    .kind (req_kind),
    .chr  (req_char),
    .row  (req_row),
    .col  (req_col),
    .ok   (dec_ok),
    .rs   (dec_rs),
    .code (dec_code)
  );

  assign tmr_val = ((byte_q == CMD_CLEAR) && !rs_q) ? CLR_M1 : SET_M1;

  lcd_seq_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .en       (st_q == S_WAIT),
    .done     (tmr_done)
  );

  always_comb begin
    st_d     = st_q;
    step_d   = step_q;
    byte_d   = byte_q;
    rs_d     = rs_q;
    err_d    = 1'b0;
    tmr_load = 1'b0;
    case (st_q)
      S_RST: begin
        step_d = '0;
        st_d   = S_INIT;
      end
      S_INIT: begin
        byte_d = rom_code;
        rs_d   = 1'b0;
        st_d   = S_ISSUE;
      end
      S_ISSUE: begin
        tmr_load = 1'b1;
        st_d     = S_WAIT;
      end
      S_WAIT: begin
        if (tmr_done) begin
          if (step_q >= LAST) begin
            step_d = FINISH;
            st_d   = S_IDLE;
          end else begin
            step_d = step_q + STEP_W'(1);
            st_d   = S_INIT;
          end
        end
      end
      S_IDLE: begin
        if (req_valid) begin
          if (dec_ok) begin
            byte_d = dec_code;
            rs_d   = dec_rs;
            st_d   = S_ISSUE;
          end else begin
            err_d = 1'b1;
          end
        end
      end
      default: st_d = S_RST;
    endcase
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      st_q   <= S_RST;
      step_q <= '0;
      byte_q <= 8'h00;
      rs_q   <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      step_q <= step_d;
      byte_q <= byte_d;
      rs_q   <= rs_d;
      err_q  <= err_d;
    end
  end

  assign req_ready = (st_q == S_IDLE);
  assign req_err   = err_q;
  assign lcd_we    = (st_q == S_ISSUE);
  assign lcd_rs    = rs_q;
  assign lcd_byte  = byte_q;

endmodule

// File: rtl/lcd_text_seq_chk.sv
module lcd_text_seq_chk #(
  parameter int SETTLE = 10000
) (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       req_ready,
  input logic [1:0] req_kind,
  input logic [7:0] req_char,
  input logic       req_err,
  input logic       lcd_we,
  input logic       lcd_rs,
  input logic [7:0] lcd_byte
);

  logic [31:0] gap_q;
  logic        seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q  <= 32'd0;
      seen_q <= 1'b0;
    end else if (lcd_we) begin
      gap_q  <= 32'd0;
      seen_q <= 1'b1;
    end else if (gap_q != 32'hFFFF_FFFF) begin
      gap_q <= gap_q + 32'd1;
    end
  end

  // R1: the outputs stay quiet while reset is held
  always_comb begin
    if (!rst_n) begin
      a_quiet_reset_r1: assert (!lcd_we && !req_ready && !req_err);
    end
  end

  p_settle_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (lcd_we && seen_q) |-> (gap_q >= 32'(SETTLE + 1)));

  p_strobe_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    lcd_we |=> !lcd_we);

  p_no_strobe_when_ready_r5: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !lcd_we);

  p_accept_answer_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (lcd_we != req_err));

  p_char_data_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_kind == 2'd0) |=>
      (lcd_we && lcd_rs && lcd_byte == $past(req_char)));

  p_err_stays_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    req_err |-> (req_ready && !lcd_we));

endmodule

bind lcd_text_seq lcd_text_seq_chk #(.SETTLE(CLK_MHZ * 100)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_kind  (req_kind),
  .req_char  (req_char),
  .req_err   (req_err),
  .lcd_we    (lcd_we),
  .lcd_rs    (lcd_rs),
  .lcd_byte  (lcd_byte)
);

// File: tb/lcd_text_seq_bench.sv
module lcd_text_seq_bench;

  localparam int CLK_MHZ  = 1;
  localparam int CLEAR_US = 300;
  localparam int ROWS     = 2;
  localparam int COLS     = 16;
  localparam int ROW_W    = 2;
  localparam int COL_W    = 5;
  localparam int S        = CLK_MHZ * 100;
  localparam int C        = CLK_MHZ * CLEAR_US;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             req_valid = 1'b0;
  logic             req_ready;
  logic [1:0]       req_kind = 2'd0;
  logic [7:0]       req_char = 8'h00;
  logic [ROW_W-1:0] req_row = '0;
  logic [COL_W-1:0] req_col = '0;
  logic             req_err;
  logic             lcd_we;
  logic             lcd_rs;
  logic [7:0]       lcd_byte;

  int cyc = 0;
  int nchk = 0;
  int nerr = 0;

  lcd_text_seq #(
    .CLK_MHZ(CLK_MHZ), .CLEAR_US(CLEAR_US), .ROWS(ROWS), .COLS(COLS),
    .ROW_W(ROW_W), .COL_W(COL_W)
  ) u_lcd_text_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .req_char(req_char), .req_row(req_row), .req_col(req_col),
    .req_err(req_err), .lcd_we(lcd_we), .lcd_rs(lcd_rs), .lcd_byte(lcd_byte)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(posedge clk) begin
    if (cyc == 150000) begin
      nerr = nerr + 1;
      nchk = nchk + 1;
      $display("FAIL watchdog: actual=%0d expected<%0d cycles", cyc, 150000);
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    nchk = nchk + 1;
    if (act != exp) begin
      nerr = nerr + 1;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_strobe(output int t);
    int n = 0;
    @(negedge clk);
    while (!lcd_we && n < 5000) begin
      @(negedge clk);
      n++;
    end
    t = cyc;
  endtask

  task automatic wait_ready(output int t);
    int n = 0;
    while (!req_ready && n < 5000) begin
      @(negedge clk);
      n++;
    end
    t = cyc;
  endtask

  task automatic send(input int kind, input int row, input int col, input int chr,
                      input bit exp_ok, input int exp_byte, input int exp_rs,
                      input string tag);
    int t0;
    int t1;
    int n = 0;
    while (!req_ready && n < 5000) begin
      @(negedge clk);
      n++;
    end
    req_kind  = 2'(kind);
    req_row   = ROW_W'(row);
    req_col   = COL_W'(col);
    req_char  = 8'(chr);
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    if (exp_ok) begin
      check({tag, " strobe (R5)"}, int'(lcd_we), 1);
      check({tag, " byte"}, int'(lcd_byte), exp_byte);
      check({tag, " rs"}, int'(lcd_rs), exp_rs);
      check({tag, " no err (R10)"}, int'(req_err), 0);
      t0 = cyc;
      @(negedge clk);
      check({tag, " strobe one cycle (R5)"}, int'(lcd_we), 0);
      wait_ready(t1);
      check({tag, " settle (R3/R4)"}, t1 - t0,
            (exp_rs == 0 && exp_byte == 1) ? C + 1 : S + 1);
    end else begin
      check({tag, " err pulse (R10)"}, int'(req_err), 1);
      check({tag, " no strobe (R10)"}, int'(lcd_we), 0);
      check({tag, " ready kept (R10)"}, int'(req_ready), 1);
      @(negedge clk);
      check({tag, " err one cycle (R10)"}, int'(req_err), 0);
      check({tag, " still no strobe (R10)"}, int'(lcd_we), 0);
    end
  endtask

  initial begin
    int init_b[5] = '{8'h38, 8'h0C, 8'h01, 8'h06, 8'h80};
    int prev = 0;
    int t;
    repeat (4) @(negedge clk);
    check("R1 we in reset", int'(lcd_we), 0);
    check("R1 ready in reset", int'(req_ready), 0);
    check("R1 err in reset", int'(req_err), 0);
    rst_n = 1'b1;

    for (int i = 0; i < 5; i++) begin
      wait_strobe(t);
      check($sformatf("R2 init byte %0d", i), int'(lcd_byte), init_b[i]);
      check($sformatf("R2 init rs %0d", i), int'(lcd_rs), 0);
      check($sformatf("R5 not ready in init %0d", i), int'(req_ready), 0);
      if (i > 0)
        check($sformatf("R3/R4 init gap %0d", i), t - prev,
              (init_b[i-1] == 8'h01) ? C + 2 : S + 2);
      prev = t;
    end
    wait_ready(t);
    check("R3 ready after init", t - prev, S + 1);

    for (int ch = 0; ch < 256; ch++)
      send(0, 0, 0, ch, 1'b1, ch, 1, "R6 char");

    send(1, 0, 0, 0, 1'b1, 8'h01, 0, "R7 clear");

    for (int r = 0; r < 4; r++)
      for (int c = 0; c < 32; c++)
        send(2, r, c, 0, (r < ROWS) && (c < COLS), 8'h80 + r * 64 + c, 0, "R8 row/col");

    for (int l = 0; l < 4; l++)
      send(3, l, 0, 0, (l >= 1) && (l <= ROWS), 8'h80 + (l - 1) * 64, 0, "R9 line");

    send(1, 0, 0, 0, 1'b1, 8'h01, 0, "R4 clear again");

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

endmodule